// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Ordering

This block produces the word address for a four-beat burst on a synchronous burst memory. It captures a base address when one of two address strobes is sampled active. It then steps the low-order burst field each time an advance input is sampled low while no strobe is active. The upper address bits stay frozen until the next load. Only the low-order field changes.

A static order-select input picks one of two orderings for the low field:

- an exclusive-OR (interleaved) sequence;
- a wrap-around linear count that stays inside the aligned block.

The two strobes follow different qualification rules. The processor-side strobe is gated by a master chip enable and takes priority. The controller-side strobe ignores the chip enable and acts only when the processor-side strobe is inactive on the same edge.

Top module: `burst_addr_seq`

## Requirements
- R1: The address bits above the burst field keep the value captured at the last load, on every cycle until the next load.
- R2: With `order_sel` = 1, the burst field on beat k (k counted from 0 at the load) equals the captured start field XOR k.
- R3: With `order_sel` = 0, the burst field on beat k equals (captured start field + k) modulo 4.
- R4: On an edge where `pstrobe_n` = 0 and `cen_mst_n` = 0, the block captures `addr_in`, restarts at beat 0 and ignores `adv_n`. From the next cycle, `addr_out` equals the captured address.
- R5: On an edge where `pstrobe_n` = 0 and `cen_mst_n` = 1, the block neither loads nor advances, even if `cstrobe_n` or `adv_n` is low.
- R6: On an edge where `cstrobe_n` = 0 and `pstrobe_n` = 1, the block captures `addr_in` and restarts at beat 0, whatever the value of `cen_mst_n`.
- R7: The beat advances by one only on an edge where `adv_n` = 0 and both strobes are 1. On any other edge with no load, `addr_out` holds.
- R8: An advance after beat 3 returns to beat 0, so `addr_out` wraps back to the captured start address. The burst never moves into the next block.
- R9: While `rst_n` = 0, the captured address and beat count are cleared, so `addr_out` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pstrobe_n | input | 1 | Processor-side address strobe, active low, gated by `cen_mst_n` |
| cstrobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cen_mst_n | input | 1 | Master chip enable, active low; qualifies only `pstrobe_n` |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Address presented for loading |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` = 10 and `BEAT_W` = 2. The address space is then small enough that random loads often repeat upper fields and every start field. That makes both the held upper bits and all sixteen start/beat pairs, in each ordering, occur many times. Directed bursts start at field values 1 and 3 to reach the wrap in both orderings. Further directed edges hold both strobes low with the chip enable off, and advance while a strobe is low. A random phase then mixes all strobe, enable and advance combinations against a per-cycle model.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } ord_e;
endpackage

// File: rtl/bsq_strobe_dec.sv
`timescale 1ns/1ps
module bsq_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic pstrobe_n,
  input  logic cstrobe_n,
  input  logic adv_n,
  input  logic cen_mst_n,
  output logic load_p,
  output logic load_c,
  output logic step
);
  // processor strobe wins; chip enable gates it alone
  assign load_p = ~pstrobe_n & ~cen_mst_n;
  assign load_c = ~cstrobe_n &  pstrobe_n;
  assign step   = ~adv_n & pstrobe_n & cstrobe_n;

  // R6: the two load sources never coincide
  a_r6_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |-> !load_c);
  // R7: an advance never shares an edge with a load
  a_r7_step_excl: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !(load_p || load_c));
endmodule

// File: rtl/bsq_beat_cnt.sv
`timescale 1ns/1ps
module bsq_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat
);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)     beat <= '0;
    else if (clear) beat <= '0;
    else if (step)  beat <= beat + 1'b1;
  end

  // R8: stepping from the last beat returns to beat 0
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step && beat == LAST) |=> beat == '0);
  // R7: no step and no load means the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(beat));
endmodule

// File: rtl/bsq_order_map.sv
`timescale 1ns/1ps
module bsq_order_map
  import bsq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  logic              order_sel,
  output logic [BEAT_W-1:0] offs
);
  function automatic logic [BEAT_W-1:0] ileave_off(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s ^ k;
  endfunction

  function automatic logic [BEAT_W-1:0] linear_off(
    input logic [BEAT_W-1:0] s, input logic [BEAT_W-1:0] k);
    return s + k;  // natural width gives the block wrap
  endfunction

  ord_e mode;
  assign mode = ord_e'(order_sel);

  always_comb begin
    if (mode == ORD_INTERLEAVE) offs = ileave_off(start, beat);
    else                        offs = linear_off(start, beat);
  end

  // R4: beat 0 always presents the captured start field in either order
  always_comb begin
    if (rst_n && beat == '0)
      a_r4_first_beat: assert (offs == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq #(
  parameter int ADDR_W = 21,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pstrobe_n,
  input  logic              cstrobe_n,
  input  logic              adv_n,
  input  logic              cen_mst_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load_p, load_c, step, load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat, offs;

  bsq_strobe_dec u_dec (
    .clk(clk), .rst_n(rst_n), .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n),
    .adv_n(adv_n), .cen_mst_n(cen_mst_n),
    .load_p(load_p), .load_c(load_c), .step(step)
  );

  assign load = load_p | load_c;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  bsq_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step), .beat(beat)
  );

  bsq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .rst_n(rst_n), .start(base_q[BEAT_W-1:0]), .beat(beat),
    .order_sel(order_sel), .offs(offs)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], offs};

  // R4: processor-strobe load shows the new address next cycle
  a_r4_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstrobe_n && !cen_mst_n) |=> addr_out == $past(addr_in));
  // R6: controller-strobe load regardless of chip enable
  a_r6_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pstrobe_n && !cstrobe_n) |=> addr_out == $past(addr_in));
  // R5: blocked processor strobe changes nothing
  a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstrobe_n && cen_mst_n) |=>
      (addr_out == $past(addr_out)) || (order_sel != $past(order_sel)));
  // R1: upper field frozen when no strobe is active
  a_r1_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pstrobe_n && cstrobe_n) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
  // R7: idle edge holds the address
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pstrobe_n && cstrobe_n && adv_n) |=>
      (addr_out == $past(addr_out)) || (order_sel != $past(order_sel)));

  initial begin
    if (UP_W < 1) $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 10;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pstrobe_n = 1'b1, cstrobe_n = 1'b1, adv_n = 1'b1, cen_mst_n = 1'b1;
  logic order_sel = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_base = 0, m_beat = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .pstrobe_n(pstrobe_n), .cstrobe_n(cstrobe_n),
    .adv_n(adv_n), .cen_mst_n(cen_mst_n), .order_sel(order_sel),
    .addr_in(addr_in), .addr_out(addr_out)
  );

  // behavioural reference, updated on the edge from the inputs held since negedge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_base = 0; m_beat = 0; tag = "R9";
    end else if (!pstrobe_n && !cen_mst_n) begin
      m_base = int'(addr_in); m_beat = 0; tag = "R4";
    end else if (!pstrobe_n) begin
      tag = "R5";
    end else if (!cstrobe_n) begin
      m_base = int'(addr_in); m_beat = 0; tag = "R6";
    end else if (!adv_n) begin
      m_beat = (m_beat + 1) % NB;
      tag = (m_beat == 0) ? "R8" : (order_sel ? "R2" : "R3");
    end else begin
      tag = "R7";
    end
  end

  function automatic int expect_addr();
    int s, lo;
    s = m_base % NB;
    if (order_sel) lo = s ^ m_beat;      // interleaved, R2
    else           lo = (s + m_beat) % NB; // linear, R3
    return (m_base / NB) * NB + lo;
  endfunction

  task automatic compare();
    int exp_a;
    exp_a = expect_addr();
    n_cmp++;
    if (int'(addr_out) / NB != m_base / NB) begin
      n_bad++;
      $display("FAIL R1 upper field: actual %0d expected %0d", int'(addr_out) / NB, m_base / NB);
    end
    n_cmp++;
    if (int'(addr_out) != exp_a) begin
      n_bad++;
      $display("FAIL %s addr_out: actual %0d expected %0d", tag, int'(addr_out), exp_a);
    end
  endtask

  task automatic edge_drive(input logic p, input logic c, input logic a,
                            input logic ce, input logic m, input int ad);
    pstrobe_n = p; cstrobe_n = c; adv_n = a; cen_mst_n = ce;
    order_sel = m; addr_in = AW'(ad);
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    compare();                                   // R9 during reset
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R4 load with advance low (ignored), interleaved burst from field 1
    edge_drive(0, 1, 0, 0, 1, 'h2A5);
    for (int i = 0; i < 5; i++) edge_drive(1, 1, 0, 1, 1, 'h3FF); // R2, R8
    edge_drive(1, 1, 1, 0, 1, 'h000);           // R7 idle
    // R6 controller load with chip enable off, linear from field 3
    edge_drive(1, 0, 0, 1, 0, 'h137);
    for (int i = 0; i < 5; i++) edge_drive(1, 1, 0, 0, 0, 'h0); // R3, R8
    // R5 blocked processor strobe with controller strobe and advance low
    edge_drive(0, 0, 0, 1, 0, 'h3C0);
    edge_drive(0, 1, 0, 1, 0, 'h3C1);
    // R7 advance ignored while a strobe is low but blocked
    edge_drive(0, 1, 0, 1, 1, 'h111);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic rp, rc, ra, re, rm;
      rp = ($urandom % 4) != 0;
      rc = ($urandom % 4) != 0;
      ra = ($urandom % 3) == 0;
      re = $urandom % 2;
      rm = (i / 50) % 2;
      edge_drive(rp, rc, ra, re, rm, int'($urandom % (1 << AW)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule